// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block places a small shared word memory behind one request port per core and keeps, next to it, one address reservation for each core. A core reads a word with a load-reserved and, later, tries to write a new value with a store-conditional. The write lands only if nothing has written that word since the reservation was taken. The status word returned to the core (zero on success, one on failure) lets software branch back and retry. With such retry loops a core can build an atomic swap or an atomic counter update.

Plain loads and stores share the same ports. A fixed-priority arbiter grants one request per cycle, so every operation, and every reservation change it causes, is totally ordered. Each core's reservation is a two-state machine with the states RSV_IDLE and RSV_HELD. Its transitions are:

- T_RESERVE: RSV_IDLE to RSV_HELD on the core's own load-reserved.
- T_REFRESH: RSV_HELD to RSV_HELD on a new load-reserved, which takes the new address.
- T_CONSUME: RSV_HELD to RSV_IDLE on the core's own store-conditional.
- T_SNOOP_KILL: RSV_HELD to RSV_IDLE when another core commits a write to the reserved word.

Top module: `lrsc_monitor`

## Requirements
- R1: The operation code on each core's two `req_op` bits is 0 = load, 1 = store, 2 = load-reserved, 3 = store-conditional. A request granted in cycle T produces `rsp_valid` for that core in cycle T+1 and for no other core. A load or load-reserved returns the word as it was before cycle T.
- R2: Only requesting cores are granted, at most one per cycle, and the lowest-numbered requesting core always wins. A core that is not granted holds its request until it is granted.
- R3: A load-reserved followed by a store-conditional to the same address from the same core, with no intervening write to that word, returns status 0 and writes the store data into memory.
- R4: A store-conditional from a core that holds no reservation returns status 1 and leaves memory unchanged. This includes the first store-conditional after reset.
- R5: A store-conditional to an address other than the one reserved by that core returns status 1 and writes nothing.
- R6: Every store-conditional clears the issuing core's reservation, whatever its outcome. A second store-conditional with no new load-reserved fails.
- R7: A plain store by another core to the reserved word clears the reservation. A store to a different word leaves it in place.
- R8: A successful store-conditional by another core to the reserved word clears the reservation.
- R9: A new load-reserved replaces the core's earlier reservation, so a store-conditional to the older address fails.
- R10: When several cores hold reservations on one word and issue store-conditionals in the same cycle, only the first one served (the lowest index) succeeds. Retry loops of all cores each complete exactly one increment.
- R11: A plain store writes its data and returns status 0.
- R12: After reset no response is valid, every memory word reads zero and no core holds a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_CORES | Request present, one bit per core |
| req_op | input | 2*NUM_CORES | Operation code per core (see R1) |
| req_addr | input | ADDR_W*NUM_CORES | Word address per core |
| req_wdata | input | DATA_W*NUM_CORES | Store data per core |
| req_grant | output | NUM_CORES | Request accepted this cycle |
| rsp_valid | output | NUM_CORES | Response present, one cycle after grant |
| rsp_data | output | DATA_W*NUM_CORES | Read data, or status word for stores and store-conditionals |

## Verification
Two events can meet in one clock edge: a store-conditional that commits a write, and the loss of a reservation held by another core on the same word. The bench provokes this by having two or four cores reserve one word and then raise their store-conditionals in the same cycle. The arbiter splits them, so the first writer's commit must kill the others' reservations before they are served. The bench judges each response against a model, which lets exactly one store-conditional per round succeed, and checks that concurrent increment loops end with a count equal to the number of cores.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } lrsc_op_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    localparam int OP_W = 2;

endpackage

// File: rtl/lrsc_arbiter.sv
module lrsc_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] gnt,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);

    // scan from the top down so the lowest requesting index is kept last
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/lrsc_mem.sv
module lrsc_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    // registered read returns the word as it stood before this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= '0;
            end
            rdata <= '0;
        end else begin
            rdata <= words_q[addr];
            if (wr_en) begin
                words_q[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/lrsc_rsv_slot.sv
module lrsc_rsv_slot
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_grant,
    input  lrsc_op_e          bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    output logic              held,
    output logic [ADDR_W-1:0] rsv_addr
);

    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_IDLE: begin
                if (own_grant && bus_op == OP_LR) begin        // T_RESERVE
                    state_d = RSV_HELD;
                    addr_d  = bus_addr;
                end
            end
            RSV_HELD: begin
                if (own_grant && bus_op == OP_LR) begin        // T_REFRESH
                    addr_d = bus_addr;
                end else if (own_grant && bus_op == OP_SC) begin // T_CONSUME
                    state_d = RSV_IDLE;
                end else if (!own_grant && bus_write && bus_addr == addr_q) begin // T_SNOOP_KILL
                    state_d = RSV_IDLE;
                end
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held     = (state_q == RSV_HELD);
        rsv_addr = addr_q;
    end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES*OP_W-1:0]     req_op,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          req_grant,
    output logic [NUM_CORES-1:0]          rsp_valid,
    output logic [NUM_CORES*DATA_W-1:0]   rsp_data
);

    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [DATA_W-1:0] ST_OK   = '0;
    localparam logic [DATA_W-1:0] ST_FAIL = DATA_W'(1);

    logic [IDX_W-1:0]  g_idx;
    logic              g_any;
    lrsc_op_e          g_op;
    logic [ADDR_W-1:0] g_addr;
    logic [DATA_W-1:0] g_wdata;
    logic              sc_ok;
    logic              wr_commit;
    logic [DATA_W-1:0] mem_rdata;

    logic [NUM_CORES-1:0] held;
    logic [ADDR_W-1:0]    rsv_addr [NUM_CORES];

    logic [NUM_CORES-1:0] rsp_valid_q;
    logic                 rsp_is_status_q;
    logic [DATA_W-1:0]    rsp_status_q;

    lrsc_arbiter #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W)
    ) u_arb (
        .req (req_valid),
        .gnt (req_grant),
        .idx (g_idx),
        .any (g_any)
    );

    // selected request
    always_comb begin
        g_op    = lrsc_op_e'(req_op[g_idx*OP_W +: OP_W]);
        g_addr  = req_addr[g_idx*ADDR_W +: ADDR_W];
        g_wdata = req_wdata[g_idx*DATA_W +: DATA_W];
    end

    // store-conditional decision and write commit
    always_comb begin
        sc_ok     = g_any && (g_op == OP_SC) && held[g_idx] && (rsv_addr[g_idx] == g_addr);
        wr_commit = g_any && ((g_op == OP_STORE) || sc_ok);
    end

    lrsc_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_commit),
        .addr  (g_addr),
        .wdata (g_wdata),
        .rdata (mem_rdata)
    );

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
        lrsc_rsv_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .own_grant (req_grant[k]),
            .bus_op    (g_op),
            .bus_addr  (g_addr),
            .bus_write (wr_commit),
            .held      (held[k]),
            .rsv_addr  (rsv_addr[k])
        );
    end

    // response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q     <= '0;
            rsp_is_status_q <= 1'b0;
            rsp_status_q    <= '0;
        end else begin
            rsp_valid_q     <= req_grant;
            rsp_is_status_q <= (g_op == OP_STORE) || (g_op == OP_SC);
            rsp_status_q    <= ((g_op == OP_SC) && !sc_ok) ? ST_FAIL : ST_OK;
        end
    end

    assign rsp_valid = rsp_valid_q;

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_rsp
        assign rsp_data[k*DATA_W +: DATA_W] =
            !rsp_valid_q[k]  ? '0 :
            rsp_is_status_q  ? rsp_status_q : mem_rdata;
    end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CORES-1:0]        req_valid,
    input logic [NUM_CORES*2-1:0]      req_op,
    input logic [NUM_CORES-1:0]        req_grant,
    input logic [NUM_CORES-1:0]        rsp_valid,
    input logic [NUM_CORES*DATA_W-1:0] rsp_data
);

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));

    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);

    p_grant_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_grant[0]);

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant != '0) |=> (rsp_valid == $past(req_grant)));

    p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant == '0) |=> (rsp_valid == '0));

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        p_sc_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_grant[k] && req_op[k*2 +: 2] == 2'd3)
            |=> (rsp_data[k*DATA_W +: DATA_W] <= DATA_W'(1)));

        p_store_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (req_grant[k] && req_op[k*2 +: 2] == 2'd1)
            |=> (rsp_data[k*DATA_W +: DATA_W] == '0));
    end

endmodule

bind lrsc_monitor lrsc_monitor_chk #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_grant (req_grant),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/test_lrsc_monitor.sv
`timescale 1ns/1ps
module test_lrsc_monitor;

    localparam int NC = 4;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [1:0] OPL = 2'd0, OPS = 2'd1, OPR = 2'd2, OPC = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    req_valid = '0;
    logic [NC*2-1:0]  req_op    = '0;
    logic [NC*AW-1:0] req_addr  = '0;
    logic [NC*DW-1:0] req_wdata = '0;
    logic [NC-1:0]    req_grant;
    logic [NC-1:0]    rsp_valid;
    logic [NC*DW-1:0] rsp_data;

    always #2.5 clk = ~clk;

    lrsc_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) i_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    int n_cmp = 0;
    int n_bad = 0;

    // scoreboard
    int          q_core [$];
    logic [DW-1:0] q_data [$];
    string       q_tag  [$];

    // reference model built from the requirements
    logic [DW-1:0] m_mem [1 << AW];
    bit            m_held [NC];
    logic [AW-1:0] m_addr [NC];
    bit            m_ok [NC];
    logic [DW-1:0] m_val [NC];

    // pending batch
    logic [NC-1:0] pend = '0;
    logic [1:0]    p_op [NC];
    logic [AW-1:0] p_addr [NC];
    logic [DW-1:0] p_wd [NC];
    string         p_tag [NC];

    function automatic logic [DW-1:0] model(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] wd);
        logic [DW-1:0] r;
        bit wr;
        r  = '0;
        wr = 1'b0;
        case (op)
            OPL: r = m_mem[a];
            OPS: wr = 1'b1;
            OPR: begin r = m_mem[a]; m_held[c] = 1'b1; m_addr[c] = a; end
            default: begin
                m_ok[c] = m_held[c] && m_addr[c] == a;
                wr = m_ok[c];
                r = m_ok[c] ? '0 : DW'(1);
                m_held[c] = 1'b0;
            end
        endcase
        if (wr) begin
            m_mem[a] = wd;
            for (int j = 0; j < NC; j++)
                if (j != c && m_held[j] && m_addr[j] == a) m_held[j] = 1'b0;
        end
        m_val[c] = (op == OPR || op == OPL) ? r : m_val[c];
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] wd, string tag);
        pend[c]   = 1'b1;
        p_op[c]   = op;
        p_addr[c] = a;
        p_wd[c]   = wd;
        p_tag[c]  = tag;
    endtask

    task automatic run_batch();
        int low;
        while (pend != '0) begin
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                req_valid[c]          = pend[c];
                req_op[c*2 +: 2]      = p_op[c];
                req_addr[c*AW +: AW]  = p_addr[c];
                req_wdata[c*DW +: DW] = p_wd[c];
            end
            #1;
            low = 0;
            for (int c = NC - 1; c >= 0; c--) if (pend[c]) low = c;
            check(req_grant == NC'(1 << low), "R2 grant order",
                  DW'(req_grant), DW'(1 << low));
            q_core.push_back(low);
            q_data.push_back(model(low, p_op[low], p_addr[low], p_wd[low]));
            q_tag.push_back(p_tag[low]);
            pend[low] = 1'b0;
        end
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic one(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] wd, string tag);
        add(c, op, a, wd, tag);
        run_batch();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NC; c++) begin
                if (rsp_valid[c]) begin
                    if (q_core.size() == 0) begin
                        check(1'b0, "R1 unexpected response", DW'(c), '1);
                    end else begin
                        check(q_core[0] == c, {q_tag[0], " (R1 responding core)"},
                              DW'(c), DW'(q_core[0]));
                        check(rsp_data[c*DW +: DW] == q_data[0], q_tag[0],
                              rsp_data[c*DW +: DW], q_data[0]);
                        void'(q_core.pop_front());
                        void'(q_data.pop_front());
                        void'(q_tag.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] done;
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        for (int c = 0; c < NC; c++) begin m_held[c] = 1'b0; m_addr[c] = '0; m_val[c] = '0; m_ok[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == '0, "R12 no response after reset", DW'(rsp_valid), '0);
        one(0, OPL, 4'd3, '0, "R12 memory zero after reset");
        one(1, OPC, 4'd3, 32'h99, "R4 SC after reset fails");
        one(1, OPS, 4'd3, 32'h11, "R11 store ack");
        one(2, OPL, 4'd3, '0, "R1 load sees store");
        one(0, OPC, 4'd3, 32'h77, "R4 SC without reservation");
        one(0, OPL, 4'd3, '0, "R4 memory untouched");
        one(0, OPR, 4'd3, '0, "R3 LR value");
        one(0, OPC, 4'd3, 32'h22, "R3 SC success");
        one(3, OPL, 4'd3, '0, "R3 SC data written");
        one(0, OPC, 4'd3, 32'h33, "R6 second SC fails");
        one(1, OPR, 4'd5, '0, "R5 LR");
        one(1, OPC, 4'd6, 32'h44, "R5 SC other address fails");
        one(1, OPL, 4'd6, '0, "R5 no write");
        one(1, OPC, 4'd5, 32'h45, "R6 SC after failed SC fails");
        one(2, OPR, 4'd7, '0, "R7 LR");
        one(3, OPS, 4'd8, 32'h5, "R7 store elsewhere");
        one(2, OPC, 4'd7, 32'h6, "R7 reservation kept");
        one(2, OPR, 4'd7, '0, "R7 LR again");
        one(3, OPS, 4'd7, 32'h8, "R7 store same word");
        one(2, OPC, 4'd7, 32'h9, "R7 reservation killed");
        one(0, OPR, 4'd9, '0, "R8 LR c0");
        one(1, OPR, 4'd9, '0, "R8 LR c1");
        one(1, OPC, 4'd9, 32'hA, "R8 SC c1 wins");
        one(0, OPC, 4'd9, 32'hB, "R8 SC c0 killed");
        one(3, OPR, 4'd10, '0, "R9 LR old");
        one(3, OPR, 4'd11, '0, "R9 LR new");
        one(3, OPC, 4'd10, 32'hC, "R9 SC old address fails");
        one(3, OPR, 4'd11, '0, "R9 LR again");
        one(3, OPC, 4'd11, 32'hD, "R9 SC new address ok");
        for (int c = 0; c < NC; c++) add(c, OPL, AW'(c), '0, "R2 four-way load");
        run_batch();
        add(1, OPR, 4'd12, '0, "R10 LR c1");
        add(2, OPR, 4'd12, '0, "R10 LR c2");
        run_batch();
        add(1, OPC, 4'd12, 32'hE1, "R10 SC c1 first");
        add(2, OPC, 4'd12, 32'hE2, "R10 SC c2 loses");
        run_batch();
        one(0, OPL, 4'd12, '0, "R10 winner data");
        done = '0;
        while (done != 4'hF) begin
            for (int c = 0; c < NC; c++) if (!done[c]) add(c, OPR, 4'd13, '0, "R10 increment LR");
            run_batch();
            for (int c = 0; c < NC; c++) if (!done[c]) add(c, OPC, 4'd13, m_val[c] + 1, "R10 increment SC");
            run_batch();
            for (int c = 0; c < NC; c++) if (!done[c] && m_ok[c]) done[c] = 1'b1;
        end
        one(0, OPL, 4'd13, '0, "R10 count equals cores");
        check(m_mem[13] == DW'(NC), "R10 model count", m_mem[13], DW'(NC));
        one(2, OPS, 4'd14, 32'h1234, "R11 store");
        one(2, OPR, 4'd14, '0, "R3 exchange LR");
        one(2, OPC, 4'd14, 32'h55AA, "R3 exchange SC");
        one(3, OPL, 4'd14, '0, "R3 exchange result");
        repeat (3) @(negedge clk);
        check(q_core.size() == 0, "R1 all responses seen", DW'(q_core.size()), '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule